// File: doc/BRIEF.md
# Delta-Sigma Packet Segmenter

The segmenter takes a continuous stream of data beats and cuts it into packets. Each packet is one header beat followed by a run of payload beats. The payload length is not fixed. A first-order delta-sigma accumulator picks it for each packet, one of two neighbouring values, so the mix of short and long packets over time carries the programmed rate ratio of the stream. A receiver can rebuild the original beat rate from the lengths alone, and can place the packet in time from the header timestamp.

Each header beat holds three fields: a packet sequence number, the timestamp taken when the packet's first data beat was accepted, and the payload length of that packet. The output side uses a valid/ready handshake. A start flag marks the header beat and an end flag marks the final payload beat. A stall at the output holds up input acceptance, and no beat is lost.

Top module: `dsm_pkt_segmenter`

## Requirements
- R1: A header beat is flagged by `out_sop` and is the only beat so flagged. With DW = 64 its layout is: bits [63:48] sequence number, [47:16] timestamp, [15:8] payload length, [7:0] zero. For other widths the same fields sit at the top of the word and the lower bits are zero.
- R2: An accumulator of ACC_W bits starts at 0 after reset. When a packet's header is emitted, it adds `rate_inc` (sampled that cycle), keeps the ACC_W-bit remainder for the next packet, and sets the payload length to NOM_LEN + carry-out. The length is therefore always NOM_LEN or NOM_LEN+1.
- R3: The payload beats are the accepted input beats, in order and unchanged. Each packet carries exactly the number of beats given in its header length field, and `out_end` is set on the last of them. Every accepted beat eventually appears at the output.
- R4: The sequence number is 0 in the first packet after reset. It rises by one per packet and wraps from 65535 to 0.
- R5: The header timestamp equals `tstamp` on the clock edge where the packet's first payload beat is accepted at the input.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data`, `out_sop` and `out_eop` hold their values until the beat is taken.
- R7: While `rst` is high and on the first cycle after it falls, `out_valid` is low and `in_ready` is high.
- R8: No beat has both `out_sop` and `out_eop` set, because every packet carries at least one payload beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_inc | input | ACC_W | Rate ratio added to the accumulator once per packet |
| tstamp | input | 32 | Free-running time counter |
| in_valid | input | 1 | Input beat present |
| in_data | input | DW | Input beat |
| in_ready | output | 1 | Input beat accepted on this edge if valid |
| out_valid | output | 1 | Output beat present |
| out_data | output | DW | Header or payload beat |
| out_sop | output | 1 | Header beat marker |
| out_eop | output | 1 | Last payload beat marker |
| out_ready | input | 1 | Downstream takes the output beat |

## Verification
The bench builds the block with NOM_LEN = 1, ACC_W = 8 and DW = 64. Packets are then one or two payload beats long, so a full cycle of 65536 sequence numbers fits in about 131k clocks and the wrap from 65535 to 0 can be reached. With the 8-bit accumulator, every 256 consecutive packets contain exactly rate_inc long ones, which gives an exact count to check for R2. The payload-length boundary cases are a rate of 0, where every packet is short, and a rate of 255, where all but one packet in 256 are long. Irregular valid and ready patterns exercise stalls that fall in the middle of a packet and on the header beat.

// File: rtl/pkt_seg_pkg.sv
package pkt_seg_pkg;

    localparam int SEQ_W = 16;
    localparam int TS_W  = 32;
    localparam int LEN_W = 8;
    localparam int HDR_W = SEQ_W + TS_W + LEN_W;

    typedef enum logic {
        ST_HDR = 1'b0,
        ST_PAY = 1'b1
    } seg_state_e;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [TS_W-1:0]  ts;
        logic [LEN_W-1:0] len;
    } seg_hdr_t;

    typedef struct packed {
        logic sop;
        logic eop;
    } seg_flags_t;

    function automatic seg_hdr_t make_hdr(input logic [SEQ_W-1:0] seq,
                                          input logic [TS_W-1:0]  ts,
                                          input logic [LEN_W-1:0] len);
        seg_hdr_t h;
        h.seq = seq;
        h.ts  = ts;
        h.len = len;
        return h;
    endfunction

endpackage

// File: rtl/dsm_len_gen.sv
module dsm_len_gen
    import pkt_seg_pkg::*;
#(
    parameter int ACC_W   = 16,
    parameter int NOM_LEN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [ACC_W-1:0] rate_inc,
    output logic [LEN_W-1:0] len_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, rate_inc};
        len_o = LEN_W'(NOM_LEN) + LEN_W'(sum[ACC_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

    assert_len_choice_R2: assert property (@(posedge clk) disable iff (rst)
        step |-> (len_o == LEN_W'(NOM_LEN)) || (len_o == LEN_W'(NOM_LEN + 1)));

endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
    import pkt_seg_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TS_W-1:0]  tstamp,
    input  logic [LEN_W-1:0] len_cur,
    output logic             hdr_fire,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic             out_sop,
    output logic             out_eop,
    input  logic             out_ready
);

    localparam int PAD_W = DW - HDR_W;

    seg_state_e       state_q;
    logic             ov_q;
    logic [DW-1:0]    od_q;
    seg_flags_t       fl_q;
    logic [DW-1:0]    pend_q;
    logic             pend_v_q;
    logic             pend_last_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [SEQ_W-1:0] seq_q;

    logic             advance;
    logic             take;
    seg_hdr_t         hdr;
    logic [DW-1:0]    hdr_word;

    always_comb begin
        advance  = !ov_q || out_ready;
        in_ready = advance && ((state_q == ST_HDR) || (cnt_q != len_q));
        hdr_fire = (state_q == ST_HDR) && advance && in_valid;
        take     = (state_q == ST_PAY) && in_valid && in_ready;
        hdr      = make_hdr(seq_q, tstamp, len_cur);
        hdr_word = DW'(hdr) << PAD_W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_HDR;
            ov_q        <= 1'b0;
            od_q        <= '0;
            fl_q        <= '0;
            pend_q      <= '0;
            pend_v_q    <= 1'b0;
            pend_last_q <= 1'b0;
            cnt_q       <= '0;
            len_q       <= '0;
            seq_q       <= '0;
        end else begin
            case (state_q)
                ST_HDR: begin
                    if (hdr_fire) begin
                        ov_q        <= 1'b1;
                        od_q        <= hdr_word;
                        fl_q        <= '{sop: 1'b1, eop: 1'b0};
                        pend_q      <= in_data;
                        pend_v_q    <= 1'b1;
                        pend_last_q <= (len_cur == LEN_W'(1));
                        cnt_q       <= LEN_W'(1);
                        len_q       <= len_cur;
                        seq_q       <= seq_q + SEQ_W'(1);
                        state_q     <= ST_PAY;
                    end else if (advance) begin
                        ov_q <= 1'b0;
                    end
                end
                ST_PAY: begin
                    if (advance) begin
                        ov_q <= pend_v_q;
                        od_q <= pend_q;
                        fl_q <= '{sop: 1'b0, eop: pend_v_q && pend_last_q};
                        if (pend_v_q && pend_last_q) begin
                            state_q <= ST_HDR;
                        end
                    end
                    if (take) begin
                        pend_q      <= in_data;
                        pend_v_q    <= 1'b1;
                        pend_last_q <= ((cnt_q + LEN_W'(1)) == len_q);
                        cnt_q       <= cnt_q + LEN_W'(1);
                    end else if (advance) begin
                        pend_v_q <= 1'b0;
                    end
                end
                default: state_q <= ST_HDR;
            endcase
        end
    end

    assign out_valid = ov_q;
    assign out_data  = od_q;
    assign out_sop   = fl_q.sop;
    assign out_eop   = fl_q.eop;

    assert_hold_out_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sop) && $stable(out_eop)));

    assert_no_accept_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sop && out_eop));

    assert_hdr_then_payload_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop && out_ready) |=> !(out_valid && out_sop));

endmodule

// File: rtl/dsm_pkt_segmenter.sv
module dsm_pkt_segmenter
    import pkt_seg_pkg::*;
#(
    parameter int DW      = 64,
    parameter int ACC_W   = 16,
    parameter int NOM_LEN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] rate_inc,
    input  logic [TS_W-1:0]  tstamp,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic             out_sop,
    output logic             out_eop,
    input  logic             out_ready
);

    localparam int LEN_LSB = DW - HDR_W;

    logic             step;
    logic [LEN_W-1:0] len_cur;

    dsm_len_gen #(
        .ACC_W   (ACC_W),
        .NOM_LEN (NOM_LEN)
    ) u_len (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .rate_inc (rate_inc),
        .len_o    (len_cur)
    );

    seg_ctrl #(
        .DW (DW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tstamp    (tstamp),
        .len_cur   (len_cur),
        .hdr_fire  (step),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_ready (out_ready)
    );

    assert_hdr_len_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |->
            ((out_data[LEN_LSB +: LEN_W] == LEN_W'(NOM_LEN)) ||
             (out_data[LEN_LSB +: LEN_W] == LEN_W'(NOM_LEN + 1))));

    assert_first_beat_R7: assert property (@(posedge clk)
        $fell(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/dsm_pkt_segmenter_tb.sv
module dsm_pkt_segmenter_tb;

    localparam int DW    = 64;
    localparam int ACC_W = 8;
    localparam int NOM   = 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst;
    logic [ACC_W-1:0] rate_inc;
    logic [31:0]      ts;
    logic             in_valid;
    logic [DW-1:0]    din;
    logic             in_ready;
    logic             out_valid;
    logic [DW-1:0]    out_data;
    logic             out_sop;
    logic             out_eop;
    logic             out_ready;

    dsm_pkt_segmenter #(.DW(DW), .ACC_W(ACC_W), .NOM_LEN(NOM)) u_dut (
        .clk(clk), .rst(rst), .rate_inc(rate_inc), .tstamp(ts),
        .in_valid(in_valid), .in_data(din), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_ready(out_ready)
    );

    always @(posedge clk) ts <= ts + 32'd1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [DW+1:0] exp_q[$];

    int unsigned m_acc;
    int          m_cnt;
    int          m_len;
    logic [15:0] m_seq;
    logic        hs_in;
    int          n_hdr, n_long, n_long_256;
    logic [15:0] last_seq;
    logic        seen_hdr, wrap_seen;
    logic        hold_pend;
    logic [DW+2:0] hold_val;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            hs_in = 1'b0;
            hold_pend = 1'b0;
        end else begin
            if (hold_pend)
                chk({out_valid, out_sop, out_eop, out_data} == hold_val, "R6",
                    "stalled beat changed", out_data, hold_val[DW-1:0]);
            if (out_valid && !out_ready)
                chk(!in_ready, "R6", "in_ready while blocked", 64'(in_ready), 64'd0);
            hold_pend = out_valid && !out_ready;
            hold_val  = {out_valid, out_sop, out_eop, out_data};

            hs_in = in_valid && in_ready;
            if (hs_in) begin
                if (m_cnt == 0) begin
                    int unsigned s;
                    s = m_acc + 32'(rate_inc);
                    m_len = NOM + int'(s >> ACC_W);
                    m_acc = s & ((32'd1 << ACC_W) - 1);
                    exp_q.push_back({1'b1, 1'b0, m_seq, ts, 8'(m_len), 8'h00});
                    m_seq = m_seq + 16'd1;
                end
                m_cnt++;
                exp_q.push_back({1'b0, (m_cnt == m_len), din});
                if (m_cnt == m_len) m_cnt = 0;
            end

            if (out_valid && out_ready) begin
                chk(!(out_sop && out_eop), "R8", "sop and eop together",
                    64'({out_sop, out_eop}), 64'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected output beat", out_data, 64'd0);
                end else begin
                    logic [DW+1:0] e;
                    e = exp_q.pop_front();
                    chk(out_sop == e[DW+1], "R1", "sop flag", 64'(out_sop), 64'(e[DW+1]));
                    if (e[DW+1]) begin
                        chk(out_data[63:48] == e[63:48], "R4", "sequence", 64'(out_data[63:48]), 64'(e[63:48]));
                        chk(out_data[47:16] == e[47:16], "R5", "timestamp", 64'(out_data[47:16]), 64'(e[47:16]));
                        chk(out_data[15:8] == e[15:8], "R2", "length", 64'(out_data[15:8]), 64'(e[15:8]));
                        chk(out_data[7:0] == 8'h00, "R1", "padding", 64'(out_data[7:0]), 64'd0);
                        n_hdr++;
                        if (out_data[15:8] == 8'(NOM + 1)) n_long++;
                        if (n_hdr == 256) n_long_256 = n_long;
                        if (seen_hdr && last_seq == 16'hFFFF && out_data[63:48] == 16'h0000)
                            wrap_seen = 1'b1;
                        last_seq = out_data[63:48];
                        seen_hdr = 1'b1;
                    end else begin
                        chk(out_data == e[DW-1:0], "R3", "payload data", out_data, e[DW-1:0]);
                        chk(out_eop == e[DW], "R3", "end flag", 64'(out_eop), 64'(e[DW]));
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic pat(input int mode, input int i);
        int unsigned h;
        h = 32'(i) * 32'd2654435761;
        case (mode)
            0: return 1'b1;
            1: return h[15];
            default: return (i % 5) != 0;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        m_acc = 0; m_cnt = 0; m_len = 0; m_seq = 16'd0;
        exp_q.delete();
        n_hdr = 0; n_long = 0; n_long_256 = -1;
        seen_hdr = 1'b0; wrap_seen = 1'b0;
        #1;
        chk(!out_valid, "R7", "out_valid in reset", 64'(out_valid), 64'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R7", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready, "R7", "in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic run(input int cycles, input int vmode, input int rmode);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            if (hs_in) din = din + 64'd1;
            in_valid  = pat(vmode, i);
            out_ready = pat(rmode, i + 7);
        end
        @(posedge clk);
        #1;
        if (hs_in) din = din + 64'd1;
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R3", "beats left undelivered", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic t_reset();
        do_reset();
    endtask

    task automatic t_fixed_rate();
        do_reset();
        rate_inc = '0;
        run(200, 0, 0);
        chk(n_long == 0, "R2", "long packets at rate 0", 64'(n_long), 64'd0);
        chk(n_hdr > 50, "R3", "packets produced", 64'(n_hdr), 64'd51);
    endtask

    task automatic t_quarter_rate();
        do_reset();
        rate_inc = 8'd64;
        run(1200, 0, 0);
        chk(n_long_256 == 64, "R2", "long packets in 256 at rate 64", 64'(n_long_256), 64'd64);
    endtask

    task automatic t_full_rate();
        do_reset();
        rate_inc = 8'd255;
        run(1200, 0, 0);
        chk(n_long_256 == 255, "R2", "long packets in 256 at rate 255", 64'(n_long_256), 64'd255);
    endtask

    task automatic t_backpressure();
        do_reset();
        rate_inc = 8'd100;
        run(3000, 1, 1);
        run(2000, 2, 1);
        run(1000, 0, 2);
    endtask

    task automatic t_seq_wrap();
        do_reset();
        rate_inc = '0;
        run(131200, 0, 0);
        chk(wrap_seen, "R4", "sequence wrap 65535 to 0", 64'(wrap_seen), 64'd1);
    endtask

    initial begin
        ts = 32'hFFFF_FF00;
        din = 64'hA5A5_0000_0000_0000;
        rate_inc = '0;
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        t_reset();
        t_fixed_rate();
        t_quarter_rate();
        t_full_rate();
        t_backpressure();
        t_seq_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule